// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and a service controller that runs firmware. The host stages up to four 32-bit words of request data and a pair of 32-bit pointers, then posts a command word. Posting the command rings a doorbell toward the controller and marks the mailbox busy. The controller reads the command, the pointers and the staged words through its own side of the block. It places up to four words of response data in a read buffer, then signals completion together with an error flag and an error code.

The host learns that a command has finished in one of two ways. It can poll the status word until busy drops. Or it can set the interrupt-on-completion flag in the command word, and the block then sends a single one-cycle interrupt pulse when the controller finishes. That pulse needs no acknowledge.

A command posted while the previous one is still busy is dropped, and a sticky overrun bit records the drop.

Top module: `mbx_ipc_regs`

## Requirements
- R1: The source pointer (byte offset 0x08) and destination pointer (0x0C) take a full 32-bit host write and read back the written value. Both are driven to the controller on `ctl_sptr` and `ctl_dptr`.
- R2: A host write whose byte enables are not all four set (`hst_be` != 4'hF) leaves the pointers and the staged write words (0x80, 0x84, 0x88, 0x8C) unchanged.
- R3: A host write to offset 0x00 while idle has the following effect one clock later: `ctl_doorbell` is high for exactly one cycle, the status busy bit is set, and `ctl_cmd` shows the written word. The command word layout is code [7:0], interrupt-on-completion [8], command id [15:12], size [23:16].
- R4: The status word at 0x04 reads as follows: busy [0], error [1], overrun [2], command id [7:4], initiator id [15:8] (taken from `hst_src_id` when the command is accepted), error code [23:16]. Bits [31:24] and [3] read zero.
- R5: A `ctl_done` pulse while busy clears busy on the next cycle. At that same edge the error bit and error code are captured from `ctl_err` and `ctl_err_code`. Both are cleared when the next command is accepted.
- R6: On completion of a command whose interrupt-on-completion bit is 1, `hst_irq` is high for exactly one cycle. It stays low when that bit is 0.
- R7: A command write while busy is ignored: no doorbell fires and `ctl_cmd` is unchanged. It does set the sticky overrun bit, which stays set until the next accepted command.
- R8: The controller fills read-buffer word `ctl_rbuf_idx` through `ctl_rbuf_we`, and the host reads it at 0x90 + 4*idx. Host writes to the read buffer have no effect.
- R9: Host reads of unmapped offsets, of the command register and of the write buffer return zero. Host writes to the status register have no effect.
- R10: A `ctl_done` pulse while idle changes no status field and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read strobe; read data is zero when low |
| hst_addr | input | 8 | Host byte address (word aligned) |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_src_id | input | 8 | Initiator id captured with each accepted command |
| hst_rdata | output | 32 | Host read data (combinational) |
| hst_irq | output | 1 | One-cycle completion interrupt |
| ctl_doorbell | output | 1 | One-cycle doorbell to the controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_wbuf_idx | input | 2 | Staged word index read by the controller |
| ctl_wbuf_data | output | 32 | Staged word at `ctl_wbuf_idx` |
| ctl_rbuf_we | input | 1 | Read-buffer word write strobe |
| ctl_rbuf_idx | input | 2 | Read-buffer word index |
| ctl_rbuf_wdata | input | 32 | Read-buffer word data |
| ctl_done | input | 1 | Completion pulse |
| ctl_err | input | 1 | Error flag sampled with completion |
| ctl_err_code | input | 8 | Error code sampled with completion |

## Verification
The hardest case is the overlap of a second command with one still in flight. It has to show that the doorbell stays quiet, that the latched command survives, and that the overrun bit persists through completion and clears only on the next accepted post. The bench gets there by posting a command, posting a different word before any completion, and then completing the first command with an error. After that it posts a fresh command with interrupt-on-completion set and checks that error, code and overrun have all been wiped. A completion pulse while idle is also issued to show that it is inert.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NWORDS  = 4;
    localparam int IDX_W   = $clog2(NWORDS);
    localparam int BE_W    = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SPTR = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DPTR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_WBUF = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_RBUF = 8'h90;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] size;
        logic [3:0] id;
        logic [2:0] rsvd_lo;
        logic       ioc;
        logic [7:0] code;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] err_code;
        logic [7:0] initiator;
        logic [3:0] cmd_id;
        logic       rsvd_lo;
        logic       overrun;
        logic       err;
        logic       busy;
    } stat_word_t;

    // Upper address bits select a 16-byte region
    function automatic logic [ADDR_W-5:0] region(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:4];
    endfunction
endpackage

// File: rtl/mbx_word_buf.sv
module mbx_word_buf
    import mbx_pkg::*;
#(
    parameter int WORDS = NWORDS,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IW-1:0]     ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/mbx_cmd_ctl.sv
module mbx_cmd_ctl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  cmd_word_t  cmd_wdata,
    input  logic [7:0] src_id,
    input  logic       done,
    input  logic       err_in,
    input  logic [7:0] err_code_in,
    output logic       busy,
    output logic       doorbell,
    output logic       irq,
    output cmd_word_t  cmd_q,
    output stat_word_t status
);
    logic       busy_q, bell_q, irq_q, err_q, ovr_q;
    logic [7:0] code_q, init_q;
    logic       accept;

    assign accept = cmd_wr && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            bell_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
            code_q <= '0;
            init_q <= '0;
            cmd_q  <= '0;
        end else begin
            bell_q <= accept;
            irq_q  <= 1'b0;
            if (accept) begin
                cmd_q  <= cmd_wdata;
                busy_q <= 1'b1;
                init_q <= src_id;
                err_q  <= 1'b0;
                code_q <= '0;
                ovr_q  <= 1'b0;
            end else if (cmd_wr) begin
                ovr_q  <= 1'b1;
            end
            if (done && busy_q) begin
                busy_q <= 1'b0;
                err_q  <= err_in;
                code_q <= err_code_in;
                irq_q  <= cmd_q.ioc;
            end
        end
    end

    assign busy     = busy_q;
    assign doorbell = bell_q;
    assign irq      = irq_q;

    always_comb begin
        status           = '0;
        status.busy      = busy_q;
        status.err       = err_q;
        status.overrun   = ovr_q;
        status.cmd_id    = cmd_q.id;
        status.initiator = init_q;
        status.err_code  = code_q;
    end
endmodule

// File: rtl/mbx_ipc_regs.sv
module mbx_ipc_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr_en,
    input  logic              hst_rd_en,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [BE_W-1:0]   hst_be,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic [7:0]        hst_src_id,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_irq,
    output logic              ctl_doorbell,
    output logic [DATA_W-1:0] ctl_cmd,
    output logic [DATA_W-1:0] ctl_sptr,
    output logic [DATA_W-1:0] ctl_dptr,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [DATA_W-1:0] ctl_wbuf_data,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [DATA_W-1:0] ctl_rbuf_wdata,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);
    logic              aligned, full_word;
    logic              hit_cmd, hit_stat, hit_sptr, hit_dptr, hit_wbuf, hit_rbuf;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] sptr_q, dptr_q, rbuf_rdata;
    logic              busy;
    cmd_word_t         cmd_q;
    stat_word_t        status;

    assign aligned   = (hst_addr[1:0] == 2'b00);
    assign full_word = (hst_be == {BE_W{1'b1}});
    assign widx      = hst_addr[2 +: IDX_W];
    assign hit_cmd   = aligned && hst_addr == OFF_CMD;
    assign hit_stat  = aligned && hst_addr == OFF_STAT;
    assign hit_sptr  = aligned && hst_addr == OFF_SPTR;
    assign hit_dptr  = aligned && hst_addr == OFF_DPTR;
    assign hit_wbuf  = aligned && region(hst_addr) == region(OFF_WBUF);
    assign hit_rbuf  = aligned && region(hst_addr) == region(OFF_RBUF);

    always_ff @(posedge clk) begin
        if (rst) begin
            sptr_q <= '0;
            dptr_q <= '0;
        end else if (hst_wr_en && full_word) begin
            if (hit_sptr) sptr_q <= hst_wdata;
            if (hit_dptr) dptr_q <= hst_wdata;
        end
    end

    mbx_cmd_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (hst_wr_en && hit_cmd),
        .cmd_wdata   (cmd_word_t'(hst_wdata)),
        .src_id      (hst_src_id),
        .done        (ctl_done),
        .err_in      (ctl_err),
        .err_code_in (ctl_err_code),
        .busy        (busy),
        .doorbell    (ctl_doorbell),
        .irq         (hst_irq),
        .cmd_q       (cmd_q),
        .status      (status)
    );

    mbx_word_buf #(.WORDS(NWORDS)) u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (hst_wr_en && full_word && hit_wbuf),
        .widx  (widx),
        .wdata (hst_wdata),
        .ridx  (ctl_wbuf_idx),
        .rdata (ctl_wbuf_data)
    );

    mbx_word_buf #(.WORDS(NWORDS)) u_rbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_rbuf_we),
        .widx  (ctl_rbuf_idx),
        .wdata (ctl_rbuf_wdata),
        .ridx  (widx),
        .rdata (rbuf_rdata)
    );

    always_comb begin
        hst_rdata = '0;
        if (hst_rd_en) begin
            if (hit_stat)      hst_rdata = status;
            else if (hit_sptr) hst_rdata = sptr_q;
            else if (hit_dptr) hst_rdata = dptr_q;
            else if (hit_rbuf) hst_rdata = rbuf_rdata;
        end
    end

    assign ctl_cmd  = cmd_q;
    assign ctl_sptr = sptr_q;
    assign ctl_dptr = dptr_q;
endmodule

// File: rtl/mbx_ipc_regs_chk.sv
module mbx_ipc_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       hst_wr_en,
    input logic [7:0] hst_addr,
    input logic       ctl_doorbell,
    input logic       hst_irq,
    input logic       ctl_done,
    input logic       busy
);
    logic cmd_wr;
    assign cmd_wr = hst_wr_en && hst_addr == 8'h00;

    // R3
    cmd_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> (busy && ctl_doorbell));

    // R3
    doorbell_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_doorbell |=> !ctl_doorbell);

    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && busy) |=> !busy);

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hst_irq |=> !hst_irq);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hst_irq) |-> $past(ctl_done && busy));

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> !ctl_doorbell);

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && !busy && !cmd_wr) |=> (!busy && !hst_irq));
endmodule

bind mbx_ipc_regs mbx_ipc_regs_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .hst_wr_en    (hst_wr_en),
    .hst_addr     (hst_addr),
    .ctl_doorbell (ctl_doorbell),
    .hst_irq      (hst_irq),
    .ctl_done     (ctl_done),
    .busy         (busy)
);

// File: tb/mbx_ipc_regs_tb_top.sv
module mbx_ipc_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        hst_wr_en, hst_rd_en;
    logic [7:0]  hst_addr;
    logic [3:0]  hst_be;
    logic [31:0] hst_wdata;
    logic [7:0]  hst_src_id;
    logic [31:0] hst_rdata;
    logic        hst_irq, ctl_doorbell;
    logic [31:0] ctl_cmd, ctl_sptr, ctl_dptr, ctl_wbuf_data;
    logic [1:0]  ctl_wbuf_idx, ctl_rbuf_idx;
    logic        ctl_rbuf_we;
    logic [31:0] ctl_rbuf_wdata;
    logic        ctl_done, ctl_err;
    logic [7:0]  ctl_err_code;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    mbx_ipc_regs dut_i (.*);

    typedef struct packed {
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'h08, 4'hF, 32'h11223344, 32'h11223344},
        '{8'h0C, 4'hF, 32'hA5A50001, 32'hA5A50001},
        '{8'h08, 4'h3, 32'hFFFFFFFF, 32'h11223344},
        '{8'h0C, 4'h1, 32'h00000000, 32'hA5A50001},
        '{8'h40, 4'hF, 32'hDEADBEEF, 32'h00000000},
        '{8'h90, 4'hF, 32'h12345678, 32'h00000000},
        '{8'h84, 4'hF, 32'hCAFEF00D, 32'h00000000},
        '{8'h04, 4'hF, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        hst_wr_en = 1'b1; hst_addr = a; hst_be = be; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0; hst_be = 4'h0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
        hst_rd_en = 1'b1; hst_addr = a;
        #1;
        d = hst_rdata;
        hst_rd_en = 1'b0;
    endtask

    task automatic ctl_complete(input logic e, input logic [7:0] code);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = code;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = 8'h00;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; hst_wr_en = 0; hst_rd_en = 0; hst_addr = 0; hst_be = 0;
        hst_wdata = 0; hst_src_id = 8'h5A; ctl_wbuf_idx = 0; ctl_rbuf_idx = 0;
        ctl_rbuf_we = 0; ctl_rbuf_wdata = 0; ctl_done = 0; ctl_err = 0; ctl_err_code = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R4)
        host_rd(8'h04, rd);
        check("R4 reset status", rd, 32'h0);
        check("R6 reset irq", {31'b0, hst_irq}, 32'h0);
        check("R3 reset doorbell", {31'b0, ctl_doorbell}, 32'h0);

        // Table: R1 R2 R8 R9
        for (int i = 0; i < NV; i++) begin
            host_wr(VEC[i].addr, VEC[i].be, VEC[i].wd);
            host_rd(VEC[i].addr, rd);
            check($sformatf("R1/R2/R8/R9 vec%0d", i), rd, VEC[i].exp);
        end
        check("R1 ctl_sptr", ctl_sptr, 32'h11223344);
        check("R1 ctl_dptr", ctl_dptr, 32'hA5A50001);

        // Write buffer via controller port (R2)
        host_wr(8'h88, 4'h7, 32'h99999999);
        ctl_wbuf_idx = 2'd1; #1;
        check("R2 wbuf word1 full write", ctl_wbuf_data, 32'hCAFEF00D);
        ctl_wbuf_idx = 2'd2; #1;
        check("R2 wbuf word2 partial ignored", ctl_wbuf_data, 32'h0);
        host_rd(8'h00, rd);
        check("R9 command reads zero", rd, 32'h0);

        // R10: completion while idle
        ctl_complete(1'b1, 8'h77);
        host_rd(8'h04, rd);
        check("R10 idle done status", rd, 32'h0);
        check("R10 idle done irq", {31'b0, hst_irq}, 32'h0);

        // R3: accept command: size 3, id 1, ioc 0, code FF
        host_wr(8'h00, 4'hF, 32'h000310FF);
        check("R3 doorbell pulse", {31'b0, ctl_doorbell}, 32'h1);
        check("R3 ctl_cmd", ctl_cmd, 32'h000310FF);
        host_rd(8'h04, rd);
        check("R4 busy status", rd, 32'h00005A11);
        @(negedge clk);
        check("R3 doorbell one cycle", {31'b0, ctl_doorbell}, 32'h0);

        // R7: command while busy
        hst_src_id = 8'h33;
        host_wr(8'h00, 4'hF, 32'h000420AA);
        check("R7 no doorbell", {31'b0, ctl_doorbell}, 32'h0);
        check("R7 cmd kept", ctl_cmd, 32'h000310FF);
        host_rd(8'h04, rd);
        check("R7 overrun set", rd, 32'h00005A15);

        // R8: controller fills read buffer
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = 2'd3; ctl_rbuf_wdata = 32'h0BADF00D;
        @(negedge clk);
        ctl_rbuf_we = 1'b0;
        host_rd(8'h9C, rd);
        check("R8 rbuf word3", rd, 32'h0BADF00D);

        // R5: completion with error, ioc clear
        ctl_complete(1'b1, 8'h33);
        check("R6 no irq when ioc clear", {31'b0, hst_irq}, 32'h0);
        host_rd(8'h04, rd);
        check("R5 err latched, R7 overrun sticky", rd, 32'h00335A16);

        // R6: command with ioc, id 2
        hst_src_id = 8'hC3;
        host_wr(8'h00, 4'hF, 32'h00012141);
        host_rd(8'h04, rd);
        check("R5/R7 cleared on accept", rd, 32'h0000C321);
        ctl_complete(1'b0, 8'h00);
        check("R6 irq pulse", {31'b0, hst_irq}, 32'h1);
        host_rd(8'h04, rd);
        check("R5 busy cleared no error", rd, 32'h0000C320);
        @(negedge clk);
        check("R6 irq one cycle", {31'b0, hst_irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule